// File: doc/BRIEF.md
# Bridge Delayed Read Request Controller

This block sits behind the downstream-facing port of a bridge and handles memory reads that masters start there. The first attempt of a read is answered with a retry. Its address, byte enables and command are latched as the one outstanding delayed read, and a request is raised on the upstream-facing port. The number of bytes in that request depends on three things: the read command, whether the address lies in the prefetchable window, and the programmed prefetch mode for that command. When the mode selects full prefetch, a programmed maximum byte count sets the size.

While the upstream data is outstanding, every attempt is retried. After the upstream side reports that the data has arrived, the next attempt that matches the latched entry completes, and the entry is freed. An optional command-swap mode lets a master that was retried repeat with a different memory read command and still match, as long as address and byte enables are identical. When the port runs in PCI-X mode, the prefetch mode fields and the swap mode are ignored.

The controller is a four-state machine:
- IDLE: no delayed read is held.
- ISSUE: the upstream request is raised and held until it is accepted.
- WAIT: the upstream data is outstanding.
- READY: the data is available.

Its transitions are:
- CAPTURE (IDLE to ISSUE): any request arrives.
- SENT (ISSUE to WAIT): `up_req_ready` is high.
- FILLED (WAIT to READY): `up_done` pulses.
- DELIVER (READY to IDLE): a matching request arrives.

Top module: `dly_read_ctrl`

## Requirements
- R1: For a prefetchable conventional-mode request whose command mode is 10 (full prefetch), the upstream byte count decodes `cfg_max_code` as follows: 000=512, 001=128, 010=256, 011=512, 100=1024, 101=2048, 110=4096, 111=512.
- R2: For a plain memory read (`req_cmd` 01; 00 is handled the same way) to a prefetchable address in conventional mode, `cfg_pf_plain` selects the size:
  - 00 or 01: one cache line of LINE_BYTES (64).
  - 10: full prefetch.
  - 11: 4 bytes.
- R3: For a read line (`req_cmd` 10) or a read multiple (`req_cmd` 11) to a prefetchable address in conventional mode, the size depends on that command's own mode field (`cfg_pf_line` or `cfg_pf_multi`):
  - 10: full prefetch.
  - 00, 01 or 11: one cache line.
- R4: A request with `req_pref` low fetches 4 bytes, whatever the modes.
- R5: With `cfg_pcix` high:
  - All prefetch modes are ignored. Prefetchable requests fetch one cache line and others fetch 4 bytes.
  - `cfg_cmd_swap` is ignored, so a changed command does not match.
- R6: A request in IDLE is answered, one cycle later, with `rsp_valid` and `rsp_retry`. In that same cycle `up_req_valid` rises, carrying the request address and byte count. Address and byte count stay stable until a cycle with `up_req_ready` high, after which `up_req_valid` falls.
- R7: Every request is retried while the upstream data is outstanding, whether it matches or not. This includes a matching request that arrives in the same cycle as `up_done`.
- R8: After `up_done`, a request with the latched address, byte enables and command is answered with `rsp_done`. The entry is then freed: no upstream request remains, and a later read starts anew.
- R9: In conventional mode, a changed command is handled as follows:
  - With `cfg_cmd_swap` low, it is retried and the entry is kept.
  - With `cfg_cmd_swap` high, it completes, provided address and byte enables are equal.
- R10: After reset, `rsp_valid`, `rsp_retry`, `rsp_done` and `up_req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pcix | input | 1 | Port runs in PCI-X mode |
| cfg_cmd_swap | input | 1 | Allow command change on repeat |
| cfg_max_code | input | 3 | Maximum byte count code for full prefetch |
| cfg_pf_plain | input | 2 | Prefetch mode for plain memory read |
| cfg_pf_line | input | 2 | Prefetch mode for read line |
| cfg_pf_multi | input | 2 | Prefetch mode for read multiple |
| req_valid | input | 1 | Read attempt present this cycle |
| req_cmd | input | 2 | Read command (01 plain, 10 line, 11 multiple) |
| req_addr | input | ADDR_W | Read address |
| req_be | input | BE_W | Byte enables |
| req_pref | input | 1 | Address lies in the prefetchable window |
| rsp_valid | output | 1 | Answer to the attempt of the previous cycle |
| rsp_retry | output | 1 | Attempt is retried |
| rsp_done | output | 1 | Attempt completes with the fetched data |
| up_req_valid | output | 1 | Upstream delayed read request |
| up_req_ready | input | 1 | Upstream request accepted |
| up_req_addr | output | ADDR_W | Upstream request address |
| up_req_bytes | output | 13 | Upstream request byte count |
| up_done | input | 1 | Upstream data has arrived |

## Verification
Two events can fall in the same cycle: the upstream data arriving and a matching repeat attempt. The bench provokes this by pulsing `up_done` in the very cycle that it presents the matching request. That attempt must be retried, and only the following attempt may complete. The same collision happens in every random transaction, so it is seen under many command, mode and address mixes, and the bench checks each time that the entry survives it.

// File: rtl/drc_pkg.sv
package drc_pkg;
    localparam int CNT_W = 13;

    typedef enum logic [1:0] {
        RD_ALT   = 2'b00,
        RD_PLAIN = 2'b01,
        RD_LINE  = 2'b10,
        RD_MULTI = 2'b11
    } rd_cmd_e;

    localparam logic [1:0] PF_FULL  = 2'b10;
    localparam logic [1:0] PF_DWORD = 2'b11;

    function automatic logic [CNT_W-1:0] max_decode(input logic [2:0] code);
        logic [CNT_W-1:0] v;
        unique case (code)
            3'b001:  v = CNT_W'(128);
            3'b010:  v = CNT_W'(256);
            3'b100:  v = CNT_W'(1024);
            3'b101:  v = CNT_W'(2048);
            3'b110:  v = CNT_W'(4096);
            default: v = CNT_W'(512);
        endcase
        return v;
    endfunction
endpackage

// File: rtl/drc_size.sv
module drc_size
    import drc_pkg::*;
#(
    parameter int LINE_BYTES = 64
) (
    input  logic [1:0]       cmd,
    input  logic             pref,
    input  logic             pcix,
    input  logic [2:0]       max_code,
    input  logic [1:0]       pf_plain,
    input  logic [1:0]       pf_line,
    input  logic [1:0]       pf_multi,
    output logic [CNT_W-1:0] bytes
);
    localparam logic [CNT_W-1:0] LINE_CNT = CNT_W'(LINE_BYTES);
    localparam logic [CNT_W-1:0] DW_CNT   = CNT_W'(4);

    rd_cmd_e    kind;
    logic [1:0] mode;

    always_comb begin
        kind = rd_cmd_e'(cmd);
        unique case (kind)
            RD_LINE:  mode = pf_line;
            RD_MULTI: mode = pf_multi;
            default:  mode = pf_plain;
        endcase
    end

    always_comb begin
        if (!pref)
            bytes = DW_CNT;
        else if (pcix)
            bytes = LINE_CNT;
        else if (mode == PF_FULL)
            bytes = max_decode(max_code);
        else if (mode == PF_DWORD && (kind == RD_PLAIN || kind == RD_ALT))
            bytes = DW_CNT;
        else
            bytes = LINE_CNT;
    end
endmodule

// File: rtl/drc_match.sv
module drc_match #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [BE_W-1:0]   ent_be,
    input  logic [1:0]        ent_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [1:0]        req_cmd,
    input  logic              swap_en,
    input  logic              pcix,
    output logic              hit
);
    logic [BE_W-1:0] lane_eq;

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign lane_eq[i] = (ent_be[i] == req_be[i]);
    end

    logic same_target;
    logic cmd_ok;

    assign same_target = (ent_addr == req_addr) && (&lane_eq);
    assign cmd_ok      = (ent_cmd == req_cmd) || (swap_en && !pcix);
    assign hit         = same_target && cmd_ok;
endmodule

// File: rtl/dly_read_ctrl.sv
module dly_read_ctrl
    import drc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BE_W       = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pcix,
    input  logic              cfg_cmd_swap,
    input  logic [2:0]        cfg_max_code,
    input  logic [1:0]        cfg_pf_plain,
    input  logic [1:0]        cfg_pf_line,
    input  logic [1:0]        cfg_pf_multi,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              req_pref,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic              rsp_done,
    output logic              up_req_valid,
    input  logic              up_req_ready,
    output logic [ADDR_W-1:0] up_req_addr,
    output logic [CNT_W-1:0]  up_req_bytes,
    input  logic              up_done
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_READY} st_e;

    st_e               state, state_nx;
    logic [ADDR_W-1:0] ent_addr;
    logic [BE_W-1:0]   ent_be;
    logic [1:0]        ent_cmd;
    logic [CNT_W-1:0]  ent_bytes;
    logic              ent_pref;
    logic [CNT_W-1:0]  new_bytes;
    logic              hit;
    logic              deliver;

    drc_size #(.LINE_BYTES(LINE_BYTES)) u_size (
        .cmd(req_cmd), .pref(req_pref), .pcix(cfg_pcix),
        .max_code(cfg_max_code), .pf_plain(cfg_pf_plain),
        .pf_line(cfg_pf_line), .pf_multi(cfg_pf_multi),
        .bytes(new_bytes)
    );

    drc_match #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_match (
        .ent_addr(ent_addr), .ent_be(ent_be), .ent_cmd(ent_cmd),
        .req_addr(req_addr), .req_be(req_be), .req_cmd(req_cmd),
        .swap_en(cfg_cmd_swap), .pcix(cfg_pcix), .hit(hit)
    );

    assign deliver = req_valid && hit && (state == ST_READY);

    // next state: CAPTURE, SENT, FILLED, DELIVER
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid)    state_nx = ST_ISSUE;
            ST_ISSUE: if (up_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (up_done)      state_nx = ST_READY;
            ST_READY: if (deliver)      state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_addr  <= '0;
            ent_be    <= '0;
            ent_cmd   <= '0;
            ent_bytes <= '0;
            ent_pref  <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            ent_addr  <= req_addr;
            ent_be    <= req_be;
            ent_cmd   <= req_cmd;
            ent_bytes <= new_bytes;
            ent_pref  <= req_pref;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_done  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_retry <= req_valid && !deliver;
            rsp_done  <= deliver;
        end
    end

    assign up_req_valid = (state == ST_ISSUE);
    assign up_req_addr  = ent_addr;
    assign up_req_bytes = ent_bytes;

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_valid && !up_req_ready |=> up_req_valid && $stable(up_req_addr) && $stable(up_req_bytes));

    a_r6_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && $onehot0({rsp_retry, rsp_done}) && (rsp_retry || rsp_done));

    a_r10_quiet_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_retry && !rsp_done);

    a_r4_dword_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_valid && !ent_pref |-> up_req_bytes == CNT_W'(4));

    a_r1_pow2_count: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_valid |-> $countones(up_req_bytes) == 1);

    a_r8_done_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(state) == ST_READY && state == ST_IDLE);

    a_r7_no_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_ISSUE) && req_valid |=> rsp_retry);
endmodule

// File: tb/sim_dly_read_ctrl.sv
`timescale 1ns/1ps
module sim_dly_read_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pcix = 0, cfg_cmd_swap = 0;
    logic [2:0]  cfg_max_code = 0;
    logic [1:0]  cfg_pf_plain = 0, cfg_pf_line = 0, cfg_pf_multi = 2'b10;
    logic        req_valid = 0, req_pref = 0;
    logic [1:0]  req_cmd = 2'b01;
    logic [31:0] req_addr = 0;
    logic [3:0]  req_be = 0;
    logic        rsp_valid, rsp_retry, rsp_done, up_req_valid;
    logic        up_req_ready = 0, up_done = 0;
    logic [31:0] up_req_addr;
    logic [12:0] up_req_bytes;

    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    dly_read_ctrl u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int max_bytes(logic [2:0] c);
        case (c)
            3'd1: return 128;
            3'd2: return 256;
            3'd4: return 1024;
            3'd5: return 2048;
            3'd6: return 4096;
            default: return 512;
        endcase
    endfunction

    function automatic int exp_bytes(logic [1:0] cmd, logic pref);
        logic [1:0] m;
        m = (cmd == 2'b10) ? cfg_pf_line : (cmd == 2'b11) ? cfg_pf_multi : cfg_pf_plain;
        if (!pref) return 4;
        if (cfg_pcix) return 64;
        if (m == 2'b10) return max_bytes(cfg_max_code);
        if (m == 2'b11 && cmd != 2'b10 && cmd != 2'b11) return 4;
        return 64;
    endfunction

    function automatic string size_tag(logic [1:0] cmd, logic pref);
        logic [1:0] m;
        m = (cmd == 2'b10) ? cfg_pf_line : (cmd == 2'b11) ? cfg_pf_multi : cfg_pf_plain;
        if (!pref) return "R4";
        if (cfg_pcix) return "R5";
        if (m == 2'b10) return "R1";
        if (cmd == 2'b01) return "R2";
        return "R3";
    endfunction

    task automatic send(logic [1:0] cmd, logic [31:0] addr, logic [3:0] be, logic pref, logic done_too);
        @(negedge clk);
        req_cmd = cmd; req_addr = addr; req_be = be; req_pref = pref;
        req_valid = 1'b1; up_done = done_too;
        @(posedge clk); #1;
        req_valid = 1'b0; up_done = 1'b0;
    endtask

    task automatic expect_rsp(string tag, logic retry);
        chk(tag, rsp_valid, 1);
        chk(tag, rsp_retry, retry);
        chk(tag, rsp_done, !retry);
    endtask

    task automatic txn(logic [1:0] cmd, logic [31:0] addr, logic [3:0] be, logic pref,
                       int hold, logic change, logic [1:0] alt);
        logic [12:0] first;
        send(cmd, addr, be, pref, 1'b0);
        expect_rsp("R6", 1'b1);
        chk("R6", up_req_valid, 1);
        chk("R6", up_req_addr, addr);
        chk(size_tag(cmd, pref), up_req_bytes, exp_bytes(cmd, pref));
        first = up_req_bytes;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            chk("R6", up_req_valid, 1);
            chk("R6", up_req_bytes, first);
        end
        @(negedge clk); up_req_ready = 1'b1;
        @(posedge clk); #1; up_req_ready = 1'b0;
        chk("R6", up_req_valid, 0);
        send(cmd, addr, be, pref, 1'b0);
        expect_rsp("R7", 1'b1);
        send(cmd, addr ^ 32'h40, be, pref, 1'b0);
        expect_rsp("R7", 1'b1);
        send(cmd, addr, be, pref, 1'b1);
        expect_rsp("R7", 1'b1);
        if (change && alt != cmd) begin
            send(alt, addr, be, pref, 1'b0);
            if (cfg_cmd_swap && !cfg_pcix) begin
                expect_rsp("R9", 1'b0);
            end else begin
                expect_rsp(cfg_pcix ? "R5" : "R9", 1'b1);
                send(cmd, addr, be ^ 4'h1, pref, 1'b0);
                expect_rsp("R8", 1'b1);
                send(cmd, addr, be, pref, 1'b0);
                expect_rsp("R8", 1'b0);
            end
        end else begin
            send(cmd, addr, be, pref, 1'b0);
            expect_rsp("R8", 1'b0);
        end
        chk("R8", up_req_valid, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R10", rsp_valid, 0);
        chk("R10", rsp_retry, 0);
        chk("R10", rsp_done, 0);
        chk("R10", up_req_valid, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 all max codes with read multiple in full prefetch
        for (int c = 0; c < 8; c++) begin
            cfg_max_code = 3'(c);
            txn(2'b11, 32'h1000 + 32'(c) * 32'h100, 4'hF, 1'b1, c % 3, 1'b0, 2'b11);
        end
        // R2 plain modes
        for (int m = 0; m < 4; m++) begin
            cfg_pf_plain = 2'(m);
            txn(2'b01, 32'h2000, 4'h3, 1'b1, 0, 1'b0, 2'b01);
        end
        // R3 line modes including reserved
        for (int m = 0; m < 4; m++) begin
            cfg_pf_line = 2'(m);
            txn(2'b10, 32'h3000, 4'hC, 1'b1, 1, 1'b0, 2'b10);
        end
        // R4 outside prefetchable window with full mode
        cfg_pf_plain = 2'b10;
        txn(2'b01, 32'h4000, 4'hF, 1'b0, 0, 1'b0, 2'b01);
        // R8 same read twice: entry was freed, second issues anew
        txn(2'b10, 32'h5000, 4'hF, 1'b1, 0, 1'b0, 2'b10);
        txn(2'b10, 32'h5000, 4'hF, 1'b1, 0, 1'b0, 2'b10);
        // R9 command change without and with swap
        cfg_cmd_swap = 1'b0;
        txn(2'b01, 32'h6000, 4'hF, 1'b1, 0, 1'b1, 2'b11);
        cfg_cmd_swap = 1'b1;
        txn(2'b01, 32'h6000, 4'hF, 1'b1, 0, 1'b1, 2'b11);
        // R5 PCI-X ignores modes and swap
        cfg_pcix = 1'b1;
        txn(2'b11, 32'h7000, 4'hF, 1'b1, 0, 1'b1, 2'b10);
        txn(2'b01, 32'h7100, 4'hF, 1'b0, 0, 1'b0, 2'b01);
        cfg_pcix = 1'b0;

        for (int n = 0; n < 60; n++) begin
            logic [1:0] cmd, alt;
            cfg_pcix     = ($urandom % 4) == 0;
            cfg_cmd_swap = 1'($urandom);
            cfg_max_code = 3'($urandom);
            cfg_pf_plain = 2'($urandom);
            cfg_pf_line  = 2'($urandom);
            cfg_pf_multi = 2'($urandom);
            cmd = 2'($urandom % 3 + 1);
            alt = 2'($urandom % 3 + 1);
            txn(cmd, $urandom & 32'hFFFF_FFFC, 4'($urandom), 1'($urandom),
                int'($urandom % 4), 1'($urandom), alt);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule